// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is the write state machine behind a small on-chip flash array. A command decoder hands it a start pulse for either a byte program or a block erase, together with an address and a data byte that it latches. The sequencer then runs the algorithm on its own. A program is a timed write phase and then a one-cycle verify. An erase has four steps over the whole addressed block: every byte is first cleared to 0x00 (precondition), the clearing is verified, every byte is then set to 0xFF, and that is verified too. A failed verify makes the sequencer repeat the write step, up to a parameterised retry budget. The array is modelled as plain registers. A read port lets the rest of the chip, or a bench, see its contents. The array has no reset, so its contents survive a reset of the sequencer.

An erase can be frozen with a suspend request and continued with a resume request. The erase then picks up at the same byte and the same phase-timer count. A programming-voltage-good input is watched in every busy state. If it drops, the operation is abandoned and reported. Asserting the active-low reset while an erase is running abandons the erase and leaves the block half-erased.

The status byte carries five flags:
- bit 7 is ready;
- bit 6 is suspended;
- bit 5 is erase error;
- bit 4 is program error;
- bit 3 is voltage low.

Bits 2..0 always read 0. States: IDLE, PROG, PROG_VFY, PRECOND, PRECOND_VFY, ERASE, ERASE_VFY, SUSP. Transitions:
- IDLE→PROG on a program start.
- IDLE→PRECOND on an erase start.
- PROG→PROG_VFY when the phase timer expires.
- PROG_VFY→IDLE on a match or when retries run out; PROG_VFY→PROG to retry.
- PRECOND→PRECOND_VFY after the last byte.
- PRECOND_VFY→ERASE after the last byte; PRECOND_VFY→PRECOND to retry.
- ERASE→ERASE_VFY after the last byte.
- ERASE_VFY→IDLE when done; ERASE_VFY→ERASE to retry.
- Any erase state→SUSP on a suspend request, and SUSP→the saved state on a resume request.
- Any busy state→IDLE on loss of programming voltage.

Top module: `flash_seq`

## Requirements
- R1: After reset the status byte reads 0x80: ready, with no flag set.
- R2: A byte program drops ready (bit 7 = 0) from the cycle after the start pulse. It stores old AND data. Ready returns once the verify matches.
- R3: If a program's verify still mismatches after MAX_RETRY retries, status bit 4 is set and the sequencer returns to ready. The byte keeps its old AND data value.
- R4: An erase sets every byte of the block that holds the latched address (address bits above the in-block offset) to 0xFF. No other block changes.
- R5: During an erase, every byte of the block reads 0x00 before any byte of it is set to 0xFF.
- R6: A suspend request during an erase gives status bits 7 and 6 both 1 from the next cycle. The array holds still while suspended. A resume request continues the erase, which then completes.
- R7: A suspend request during a byte program is ignored: bit 6 stays 0 and the program completes.
- R8: If the programming-voltage-good input is low in a busy state, the operation stops. The next cycle shows ready, bit 3 set, and bit 5 set (erase) or bit 4 set (program).
- R9: Bits 5..3 stay set until a clear request arrives. A clear request clears them in the next cycle.
- R10: A start request while the sequencer is busy is ignored.
- R11: Reset during an erase returns the sequencer to ready at once. The block is left partly erased: bytes already set read 0xFF, later bytes still read 0x00.
- R12: Status bits 2..0 are always 0, and bit 6 is never 1 without bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer (not the array) |
| start_prog | input | 1 | Begin a byte program using op_addr/op_data |
| start_erase | input | 1 | Begin an erase of the block containing op_addr |
| suspend_req | input | 1 | Freeze an erase in progress |
| resume_req | input | 1 | Continue a suspended erase |
| clear_req | input | 1 | Clear status bits 5..3 |
| vpp_ok | input | 1 | Programming voltage present |
| op_addr | input | ADDR_W | Operation address, latched at start |
| op_data | input | DATA_W | Program data, latched at start |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array contents at rd_addr (combinational) |
| status | output | 8 | Status byte |

## Verification
The hardest case to reach is a reset that lands inside the erase phase, after the first byte has turned to 0xFF but before the last one has. Every such byte has to have gone through precondition first. The bench reaches this window without knowing the internal timing. It watches the first byte of the block through the read port, waits for it to fall to 0x00 and then rise to 0xFF, and at that same moment either samples the last byte (ordering check) or pulls reset (abort check). Suspend is hit by counting cycles into the precondition, and a voltage drop by lowering the input mid-erase and at the start of a program.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_PROG_VFY,
        ST_PRECOND,
        ST_PRECOND_VFY,
        ST_ERASE,
        ST_ERASE_VFY,
        ST_SUSP
    } seq_state_t;

    localparam int SR_READY     = 7;
    localparam int SR_SUSP      = 6;
    localparam int SR_ERASE_ERR = 5;
    localparam int SR_PROG_ERR  = 4;
    localparam int SR_VPP_LOW   = 3;

    function automatic logic in_erase(input seq_state_t s);
        return (s == ST_PRECOND) || (s == ST_PRECOND_VFY) ||
               (s == ST_ERASE)   || (s == ST_ERASE_VFY);
    endfunction

    function automatic logic in_timed(input seq_state_t s);
        return (s == ST_PROG) || (s == ST_PRECOND) || (s == ST_ERASE);
    endfunction

endpackage

// File: rtl/flash_seq_array.sv
module flash_seq_array #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    // Cell contents survive sequencer reset on purpose.
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int PHASE_CYC = 4,
    localparam int CW = $clog2(PHASE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);

    logic [CW-1:0] cnt;

    assign done = en && (cnt == CW'(PHASE_CYC - 1));

    // Holds its count while en is low, so a suspended phase resumes mid-way.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= done ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int BLOCK_BYTES = 8,
    parameter int MAX_RETRY   = 3,
    localparam int OFF_W = $clog2(BLOCK_BYTES),
    localparam int RW    = $clog2(MAX_RETRY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic              clear_req,
    input  logic              vpp_ok,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic              tmr_done,
    output logic              tmr_en,
    output logic              tmr_clr,
    output logic [ADDR_W-1:0] cell_addr,
    input  logic [DATA_W-1:0] cell_data,
    output logic              we,
    output logic [DATA_W-1:0] wdata,
    output logic [7:0]        status
);

    seq_state_t        state, next_state, saved_state;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic [OFF_W-1:0]  idx;
    logic [RW-1:0]     retry_cnt;
    logic              err_erase, err_prog, vpp_low;

    logic latch, idx_clr, idx_inc, retry_inc, save_state;
    logic set_erase_err, set_prog_err, set_vpp;
    logic last_byte, retry_left;

    assign last_byte  = (idx == OFF_W'(BLOCK_BYTES - 1));
    assign retry_left = (retry_cnt < RW'(MAX_RETRY));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    // Next state and datapath strobes
    always_comb begin
        next_state    = state;
        latch         = 1'b0;
        idx_clr       = 1'b0;
        idx_inc       = 1'b0;
        retry_inc     = 1'b0;
        save_state    = 1'b0;
        set_erase_err = 1'b0;
        set_prog_err  = 1'b0;
        set_vpp       = 1'b0;
        if (state != ST_IDLE && state != ST_SUSP && !vpp_ok) begin
            set_vpp = 1'b1;
            if (in_erase(state)) set_erase_err = 1'b1;
            else                 set_prog_err  = 1'b1;
            next_state = ST_IDLE;
        end else if (in_erase(state) && suspend_req) begin
            save_state = 1'b1;
            next_state = ST_SUSP;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_prog) begin
                        latch      = 1'b1;
                        next_state = ST_PROG;
                    end else if (start_erase) begin
                        latch      = 1'b1;
                        next_state = ST_PRECOND;
                    end
                end
                ST_PROG: begin
                    if (tmr_done) next_state = ST_PROG_VFY;
                end
                ST_PROG_VFY: begin
                    if (cell_data == lat_data) begin
                        next_state = ST_IDLE;
                    end else if (retry_left) begin
                        retry_inc  = 1'b1;
                        next_state = ST_PROG;
                    end else begin
                        set_prog_err = 1'b1;
                        next_state   = ST_IDLE;
                    end
                end
                ST_PRECOND: begin
                    if (tmr_done) begin
                        if (last_byte) begin
                            idx_clr    = 1'b1;
                            next_state = ST_PRECOND_VFY;
                        end else begin
                            idx_inc = 1'b1;
                        end
                    end
                end
                ST_PRECOND_VFY: begin
                    if (cell_data == '0) begin
                        if (last_byte) begin
                            idx_clr    = 1'b1;
                            next_state = ST_ERASE;
                        end else begin
                            idx_inc = 1'b1;
                        end
                    end else if (retry_left) begin
                        retry_inc  = 1'b1;
                        next_state = ST_PRECOND;
                    end else begin
                        set_erase_err = 1'b1;
                        next_state    = ST_IDLE;
                    end
                end
                ST_ERASE: begin
                    if (tmr_done) begin
                        if (last_byte) begin
                            idx_clr    = 1'b1;
                            next_state = ST_ERASE_VFY;
                        end else begin
                            idx_inc = 1'b1;
                        end
                    end
                end
                ST_ERASE_VFY: begin
                    if (cell_data == '1) begin
                        if (last_byte) begin
                            next_state = ST_IDLE;
                        end else begin
                            idx_inc = 1'b1;
                        end
                    end else if (retry_left) begin
                        retry_inc  = 1'b1;
                        next_state = ST_ERASE;
                    end else begin
                        set_erase_err = 1'b1;
                        next_state    = ST_IDLE;
                    end
                end
                ST_SUSP: begin
                    if (resume_req) next_state = saved_state;
                end
                default: next_state = ST_IDLE;
            endcase
        end
    end

    // Datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saved_state <= ST_IDLE;
            lat_addr    <= '0;
            lat_data    <= '0;
            idx         <= '0;
            retry_cnt   <= '0;
            err_erase   <= 1'b0;
            err_prog    <= 1'b0;
            vpp_low     <= 1'b0;
        end else begin
            if (latch) begin
                lat_addr  <= op_addr;
                lat_data  <= op_data;
                idx       <= '0;
                retry_cnt <= '0;
            end else begin
                if (idx_clr)        idx <= '0;
                else if (idx_inc)   idx <= idx + 1'b1;
                if (retry_inc)      retry_cnt <= retry_cnt + 1'b1;
            end
            if (save_state) saved_state <= state;
            err_erase <= set_erase_err | (err_erase & ~clear_req);
            err_prog  <= set_prog_err  | (err_prog  & ~clear_req);
            vpp_low   <= set_vpp       | (vpp_low   & ~clear_req);
        end
    end

    // Outputs
    always_comb begin
        tmr_clr   = (state == ST_IDLE);
        tmr_en    = in_timed(state) && vpp_ok &&
                    !(suspend_req && state != ST_PROG);
        cell_addr = (state == ST_PROG || state == ST_PROG_VFY) ?
                    lat_addr : {lat_addr[ADDR_W-1:OFF_W], idx};
        we        = in_timed(state) && tmr_done;
        unique case (state)
            ST_PROG:    wdata = cell_data & lat_data;
            ST_PRECOND: wdata = '0;
            default:    wdata = '1;
        endcase
        status = '0;
        status[SR_READY]     = (state == ST_IDLE) || (state == ST_SUSP);
        status[SR_SUSP]      = (state == ST_SUSP);
        status[SR_ERASE_ERR] = err_erase;
        status[SR_PROG_ERR]  = err_prog;
        status[SR_VPP_LOW]   = vpp_low;
    end

endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_BYTES = 8,
    parameter int DATA_W      = 8,
    parameter int PHASE_CYC   = 4,
    parameter int MAX_RETRY   = 3,
    localparam int DEPTH  = NUM_BLOCKS * BLOCK_BYTES,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic              clear_req,
    input  logic              vpp_ok,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        status
);

    logic              tmr_en, tmr_clr, tmr_done, we;
    logic [ADDR_W-1:0] cell_addr;
    logic [DATA_W-1:0] cell_data, wdata;

    flash_seq_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .en   (tmr_en),
        .done (tmr_done)
    );

    flash_seq_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .we     (we),
        .waddr  (cell_addr),
        .wdata  (wdata),
        .raddr_a(rd_addr),
        .rdata_a(rd_data),
        .raddr_b(cell_addr),
        .rdata_b(cell_data)
    );

    flash_seq_ctrl #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .BLOCK_BYTES(BLOCK_BYTES),
        .MAX_RETRY  (MAX_RETRY)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_prog (start_prog),
        .start_erase(start_erase),
        .suspend_req(suspend_req),
        .resume_req (resume_req),
        .clear_req  (clear_req),
        .vpp_ok     (vpp_ok),
        .op_addr    (op_addr),
        .op_data    (op_data),
        .tmr_done   (tmr_done),
        .tmr_en     (tmr_en),
        .tmr_clr    (tmr_clr),
        .cell_addr  (cell_addr),
        .cell_data  (cell_data),
        .we         (we),
        .wdata      (wdata),
        .status     (status)
    );

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_prog,
    input logic              start_erase,
    input logic              resume_req,
    input logic              clear_req,
    input logic              vpp_ok,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [7:0]        status
);

    p_low_bits_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        status[2:0] == 3'b000);

    p_susp_implies_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> status[7]);

    p_clear_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && status[7] && !status[6]) |=> (status[5:3] == 3'b000));

    p_erase_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !clear_req) |=> status[5]);

    p_vpp_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[7] && !vpp_ok) |=> (status[7] && status[3]));

    p_susp_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && !resume_req) |=> status[6]);

    p_susp_array_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && $past(status[6]) && $stable(rd_addr)) |-> $stable(rd_data));

    p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !status[6] && !start_prog && !start_erase) |=>
        (status[7] && !status[6]));

endmodule

bind flash_seq flash_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_prog (start_prog),
    .start_erase(start_erase),
    .resume_req (resume_req),
    .clear_req  (clear_req),
    .vpp_ok     (vpp_ok),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .status     (status)
);

// File: tb/flash_seq_tb_top.sv
module flash_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int BB = 8;
    localparam int AW = 5;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_prog = 1'b0, start_erase = 1'b0;
    logic          suspend_req = 1'b0, resume_req = 1'b0, clear_req = 1'b0;
    logic          vpp_ok = 1'b1;
    logic [AW-1:0] op_addr = '0, rd_addr = '0;
    logic [DW-1:0] op_data = '0;
    logic [DW-1:0] rd_data;
    logic [7:0]    status;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] val;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    logic [DW-1:0] ref_mem [NB*BB];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_seq #(.NUM_BLOCKS(NB), .BLOCK_BYTES(BB), .DATA_W(DW),
                .PHASE_CYC(4), .MAX_RETRY(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
        .suspend_req(suspend_req), .resume_req(resume_req), .clear_req(clear_req),
        .vpp_ok(vpp_ok), .op_addr(op_addr), .op_data(op_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Driver side: queue expected contents of a block
    task automatic push_block(input int b, input string tag);
        for (int i = 0; i < BB; i++) begin
            exp_t e;
            e.addr = AW'(b*BB + i);
            e.val  = ref_mem[b*BB + i];
            e.tag  = tag;
            sb_q.push_back(e);
        end
    endtask

    // Monitor side: pop expected items and compare with the read port
    task automatic drain();
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            @(negedge clk);
            rd_addr = e.addr;
            #1;
            check(e.tag, int'(rd_data), int'(e.val));
        end
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!status[7] && n < 2000);
        if (!status[7]) check({tag, " timeout"}, 0, 1);
    endtask

    task automatic poll_byte(input logic [AW-1:0] a, input logic [DW-1:0] v, input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            rd_addr = a;
            #1;
            n++;
        end while (rd_data != v && n < 2000);
        if (rd_data != v) check({tag, " poll"}, int'(rd_data), int'(v));
    endtask

    task automatic kick_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        start_prog = 1'b1; op_addr = a; op_data = d;
        @(negedge clk);
        start_prog = 1'b0;
    endtask

    task automatic kick_erase(input logic [AW-1:0] a);
        @(negedge clk);
        start_erase = 1'b1; op_addr = a;
        @(negedge clk);
        start_erase = 1'b0;
    endtask

    task automatic do_prog(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        kick_prog(a, d);
        check({tag, " busy"}, int'(status[7]), 0);
        wait_ready(tag);
        ref_mem[a] = ref_mem[a] & d;
    endtask

    task automatic do_erase(input logic [AW-1:0] a, input string tag);
        kick_erase(a);
        check({tag, " busy"}, int'(status[7]), 0);
        wait_ready(tag);
        for (int i = 0; i < BB; i++) ref_mem[(a / BB) * BB + i] = 8'hFF;
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear_req = 1'b1;
        @(negedge clk); clear_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", int'(status), 'h80);

        // R4: erase every block
        for (int b = 0; b < NB; b++) do_erase(AW'(b*BB + 1), "R4 erase all");
        for (int b = 0; b < NB; b++) push_block(b, "R4 block erased");
        drain();
        check("R4 status clean", int'(status), 'h80);

        // R2: program and AND behaviour
        do_prog(5'h03, 8'hA5, "R2 program");
        do_prog(5'h03, 8'h21, "R2 and-subset");
        check("R2 status", int'(status), 'h80);
        push_block(0, "R2 contents");
        drain();

        // R3: program that cannot verify
        do_prog(5'h04, 8'h3C, "R3 first");
        do_prog(5'h04, 8'h0F, "R3 clash");
        check("R3 prog error flag", int'(status), 'h90);
        push_block(0, "R3 contents");
        drain();

        // R9: sticky then cleared
        repeat (5) @(negedge clk);
        check("R9 sticky", int'(status), 'h90);
        pulse_clear();
        check("R9 cleared", int'(status), 'h80);

        // R5 and R10: ordering in block 1, busy start ignored
        do_prog(5'h0F, 8'h5A, "R5 setup");
        kick_erase(5'h09);
        kick_prog(5'h1A, 8'h00);
        poll_byte(5'h08, 8'h00, "R5");
        poll_byte(5'h08, 8'hFF, "R5");
        rd_addr = 5'h0F;
        #1;
        check("R5 last byte preconditioned", int'(rd_data), 'h00);
        wait_ready("R5 erase");
        for (int i = 0; i < BB; i++) ref_mem[BB + i] = 8'hFF;
        check("R10 no error", int'(status), 'h80);
        push_block(1, "R5 block1 erased");
        push_block(3, "R10 block3 untouched");
        drain();

        // R6: suspend and resume in block 2
        do_prog(5'h14, 8'h00, "R6 setup");
        kick_erase(5'h12);
        repeat (12) @(negedge clk);
        suspend_req = 1'b1;
        @(negedge clk);
        suspend_req = 1'b0;
        check("R6 suspended status", int'(status), 'hC0);
        begin
            logic [DW-1:0] snap;
            rd_addr = 5'h14;
            #1;
            snap = rd_data;
            repeat (30) @(negedge clk);
            #1;
            check("R6 array held", int'(rd_data), int'(snap));
        end
        check("R6 still suspended", int'(status), 'hC0);
        resume_req = 1'b1;
        @(negedge clk);
        resume_req = 1'b0;
        check("R6 resumed busy", int'(status[7]), 0);
        wait_ready("R6 erase");
        for (int i = 0; i < BB; i++) ref_mem[2*BB + i] = 8'hFF;
        check("R6 done", int'(status), 'h80);
        push_block(2, "R6 block2 erased");
        drain();

        // R7: suspend during program ignored
        kick_prog(5'h11, 8'h12);
        suspend_req = 1'b1;
        @(negedge clk);
        suspend_req = 1'b0;
        check("R7 not suspended", int'(status[6]), 0);
        wait_ready("R7");
        ref_mem[5'h11] = 8'h12;
        check("R7 status", int'(status), 'h80);
        push_block(2, "R7 contents");
        drain();

        // R8: voltage loss in erase and in program
        kick_erase(5'h18);
        repeat (5) @(negedge clk);
        vpp_ok = 1'b0;
        @(negedge clk);
        check("R8 erase abort", int'(status), 'hA8);
        vpp_ok = 1'b1;
        pulse_clear();
        check("R8 cleared", int'(status), 'h80);
        vpp_ok = 1'b0;
        kick_prog(5'h19, 8'h00);
        wait_ready("R8 prog");
        check("R8 prog abort", int'(status), 'h98);
        vpp_ok = 1'b1;
        pulse_clear();
        do_erase(5'h18, "R8 restore");
        push_block(3, "R8 block3 restored");
        drain();

        // R11: reset in the erase phase of block 0
        kick_erase(5'h02);
        poll_byte(5'h00, 8'h00, "R11");
        poll_byte(5'h00, 8'hFF, "R11");
        rst_n = 1'b0;
        #1;
        check("R11 ready at reset", int'(status), 'h80);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rd_addr = 5'h00;
        #1;
        check("R11 first byte erased", int'(rd_data), 'hFF);
        rd_addr = 5'h07;
        #1;
        check("R11 last byte partial", int'(rd_data), 'h00);
        do_erase(5'h00, "R11 re-erase");
        push_block(0, "R11 block0 restored");
        drain();
        check("R12 low bits", int'(status[2:0]), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule